// File: doc/BRIEF.md
# Digital loss-of-signal detector

This block watches a receive stream of pulse positions, one position per cycle in which the clock-enable `tick` is high. The `pulse_in` bit is 1 when a pulse was seen on either rail. A long unbroken run of empty positions raises a loss-of-signal alarm. After that, the block judges the stream in fixed blocks of positions. The alarm drops at the end of the first block that carries enough pulses.

Raising and clearing use different tests. Raising counts consecutive zeros. Clearing checks the ones density over a block. In the strict standard it also requires that no zero run inside the block is too long. The standard-select input is only taken while the alarm is low, or at a block boundary, so a block is never judged under two rules. Two one-cycle event pulses accompany each rise and fall of the alarm, so an alarm register can latch them.

Top module: `dlos_detector`

## Requirements
- R1: After synchronous reset, `alarm`, `set_evt` and `clr_evt` are all 0.
- R2: With `alarm` low, the tick that delivers the 100th consecutive zero raises `alarm` at that clock edge. A run of 99 zeros does not raise it.
- R3: `set_evt` is high for exactly the one cycle in which `alarm` has just risen. `clr_evt` is high for exactly the one cycle in which `alarm` has just fallen. The two are never high together.
- R4: A cycle with `tick` low has no effect, whatever `pulse_in` is. It changes no output, no zero count, no block position and no ones count.
- R5: While `alarm` is high, positions are grouped in non-overlapping blocks of 100 ticks. The first block starts with the first tick after the rise. At the edge of a block's 100th tick, `alarm` falls if the block held at least 13 ones. Otherwise a fresh block starts.
- R6: When the standard in force is 1 (strict), a block also fails if it contains a run of more than 15 consecutive zeros. Runs are counted from the block's own first position. When the standard is 0, run length inside the block is not checked.
- R7: `std_sel` is taken into use on every cycle while `alarm` is low, and on the tick that ends a block. A change in the middle of a block does not affect that block's verdict, but does apply to the next block.
- R8: The consecutive-zero count follows the live stream at all times. Any one resets it to zero, and it saturates at 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock-enable: one pulse position per high cycle |
| pulse_in | input | 1 | 1 when a pulse is present in this position |
| std_sel | input | 1 | Clearing standard: 0 density only, 1 density plus zero-run bound |
| alarm | output | 1 | Loss-of-signal alarm, registered |
| set_evt | output | 1 | One-cycle pulse when the alarm rises |
| clr_evt | output | 1 | One-cycle pulse when the alarm falls |

## Verification
All three outputs are registered. Each one therefore changes at the same clock edge that samples the deciding tick: the 100th zero for raising, or the last position of a block for clearing. The event pulses go low again at the following edge. The bench drives inputs at the falling edge. It samples outputs 2 ns after the rising edge that consumes the final tick of each stimulus, and one cycle later again to confirm that the event pulses are gone. Sweeps over zero-run length, ones count per block and zero-run length inside a block compare each verdict with a threshold the bench computes arithmetically.

// File: rtl/dlos_pkg.sv
package dlos_pkg;
  typedef enum logic {
    STD_DENSITY     = 1'b0,
    STD_DENSITY_RUN = 1'b1
  } dlos_std_e;
endpackage

// File: rtl/dlos_zero_run.sv
module dlos_zero_run #(
  parameter int SET_ZEROS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic bit_in,
  output logic hit
);
  localparam int CW = $clog2(SET_ZEROS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (bit_in)
        cnt_q <= '0;
      else if (cnt_q != CW'(SET_ZEROS))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  // this tick supplies the SET_ZEROS-th (or later) zero in a row
  assign hit = tick && !bit_in && (cnt_q >= CW'(SET_ZEROS - 1));

  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(SET_ZEROS)); // R8
  AST_ONE_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
    (tick && bit_in) |=> (cnt_q == '0)); // R8
  AST_IDLE_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/dlos_window.sv
module dlos_window #(
  parameter int WIN_LEN  = 100,
  parameter int MIN_ONES = 13,
  parameter int MAX_RUN  = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  input  logic bit_in,
  input  logic strict,
  output logic last,
  output logic pass
);
  localparam int PW = $clog2(WIN_LEN);
  localparam int OW = $clog2(WIN_LEN + 1);
  localparam int RW = $clog2(MAX_RUN + 2);

  logic [PW-1:0] pos_q;
  logic [OW-1:0] ones_q, ones_nxt;
  logic [RW-1:0] run_q, run_nxt;
  logic          viol_q, viol_nxt;

  always_comb begin
    ones_nxt = ones_q + OW'(bit_in);
    if (bit_in)
      run_nxt = '0;
    else if (run_q == RW'(MAX_RUN + 1))
      run_nxt = run_q;
    else
      run_nxt = run_q + 1'b1;
    viol_nxt = viol_q || (run_nxt > RW'(MAX_RUN));
  end

  assign last = active && tick && (pos_q == PW'(WIN_LEN - 1));
  assign pass = (ones_nxt >= OW'(MIN_ONES)) && (!strict || !viol_nxt);

  always_ff @(posedge clk) begin
    if (rst || !active || last) begin
      pos_q  <= '0;
      ones_q <= '0;
      run_q  <= '0;
      viol_q <= 1'b0;
    end else if (tick) begin
      pos_q  <= pos_q + 1'b1;
      ones_q <= ones_nxt;
      run_q  <= run_nxt;
      viol_q <= viol_nxt;
    end
  end

  AST_POS_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    pos_q < PW'(WIN_LEN)); // R5
  AST_ONES_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    OW'(pos_q) >= ones_q); // R5
  AST_IDLE_HOLDS_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (active && !tick) |=> (active -> $stable(pos_q))); // R4
endmodule

// File: rtl/dlos_detector.sv
module dlos_detector
  import dlos_pkg::*;
#(
  parameter int SET_ZEROS = 100,
  parameter int WIN_LEN   = 100,
  parameter int MIN_ONES  = 13,
  parameter int MAX_RUN   = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pulse_in,
  input  logic std_sel,
  output logic alarm,
  output logic set_evt,
  output logic clr_evt
);
  logic      hit, win_last, win_pass;
  dlos_std_e mode_q;

  dlos_zero_run #(.SET_ZEROS(SET_ZEROS)) u_run (
    .clk(clk), .rst(rst), .tick(tick), .bit_in(pulse_in), .hit(hit)
  );

  dlos_window #(.WIN_LEN(WIN_LEN), .MIN_ONES(MIN_ONES), .MAX_RUN(MAX_RUN)) u_win (
    .clk(clk), .rst(rst), .active(alarm), .tick(tick), .bit_in(pulse_in),
    .strict(mode_q == STD_DENSITY_RUN), .last(win_last), .pass(win_pass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm   <= 1'b0;
      set_evt <= 1'b0;
      clr_evt <= 1'b0;
      mode_q  <= STD_DENSITY;
    end else begin
      set_evt <= !alarm && hit;
      clr_evt <= win_last && win_pass;
      if (!alarm && hit)
        alarm <= 1'b1;
      else if (win_last && win_pass)
        alarm <= 1'b0;
      // the standard only changes between blocks
      if (!alarm || win_last)
        mode_q <= dlos_std_e'(std_sel);
    end
  end

  AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    set_evt |-> (alarm && !$past(alarm))); // R3
  AST_CLR_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    clr_evt |-> (!alarm && $past(alarm))); // R3
  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(set_evt && clr_evt)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(alarm)); // R4
  AST_FALL_AT_BLOCK_END: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm) |-> $past(win_last)); // R5
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (alarm && !win_last) |=> $stable(mode_q)); // R7
endmodule

// File: tb/dlos_detector_tb.sv
module dlos_detector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic pulse_in = 1'b0;
  logic std_sel = 1'b0;
  logic alarm, set_evt, clr_evt;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dlos_detector dut_i (
    .clk(clk), .rst(rst), .tick(tick), .pulse_in(pulse_in), .std_sel(std_sel),
    .alarm(alarm), .set_evt(set_evt), .clr_evt(clr_evt)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog (R1..): actual=%0d cycles expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit tk, bit b);
    @(negedge clk);
    tick = tk;
    pulse_in = b;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tick = 1'b0;
    pulse_in = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic enter_alarm(bit sel);
    do_reset();
    std_sel = sel;
    repeat (100) step(1'b1, 1'b0);
    chk("R2 alarm after 100 zeros", alarm, 1);
  endtask

  function automatic logic [99:0] burst(int k);
    logic [99:0] w = '0;
    for (int i = 0; i < k; i++) w[i] = 1'b1;
    return w;
  endfunction

  function automatic logic [99:0] runpat(int len);
    logic [99:0] w = '0;
    for (int i = len; i < 100; i++) w[i] = ((i - len) % 2 == 0);
    return w;
  endfunction

  function automatic logic [99:0] spaced(int k);
    logic [99:0] w = '0;
    for (int i = 0; i < 8 * k; i++) w[i] = (i % 8 == 0);
    return w;
  endfunction

  task automatic win(logic [99:0] w, int sw_at, bit sw_val, bit gaps);
    for (int i = 0; i < 100; i++) begin
      if (i == sw_at) std_sel = sw_val;
      if (gaps) step(1'b0, 1'b1);
      step(1'b1, w[i]);
      if (i == 98) chk("R5 alarm held inside block", alarm, 1);
    end
  endtask

  initial begin
    do_reset();
    chk("R1 alarm", alarm, 0);
    chk("R1 set_evt", set_evt, 0);
    chk("R1 clr_evt", clr_evt, 0);

    // R2 sweep of zero-run length
    for (int n = 95; n < 105; n++) begin
      do_reset();
      std_sel = 1'b0;
      repeat (n) step(1'b1, 1'b0);
      chk($sformatf("R2 alarm after %0d zeros", n), alarm, int'(n >= 100));
      chk($sformatf("R3 set_evt after %0d zeros", n), set_evt, int'(n == 100));
      if (n == 100) begin
        step(1'b0, 1'b0);
        chk("R3 set_evt drops", set_evt, 0);
        chk("R3 alarm stays", alarm, 1);
      end
    end

    // R8 a one restarts the count
    do_reset();
    repeat (99) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    repeat (99) step(1'b1, 1'b0);
    chk("R8 one resets zero count", alarm, 0);
    step(1'b1, 1'b0);
    chk("R8 100 zeros after one", alarm, 1);

    // R4 idle cycles with pulses do not break the zero run
    do_reset();
    repeat (99) step(1'b1, 1'b0);
    repeat (10) step(1'b0, 1'b1);
    chk("R4 no tick no set", alarm, 0);
    chk("R4 no tick no event", set_evt, 0);
    step(1'b1, 1'b0);
    chk("R4 untick pulses ignored", alarm, 1);

    // R5 ones-count sweep, density standard
    for (int k = 0; k <= 20; k++) begin
      enter_alarm(1'b0);
      win(burst(k), -1, 1'b0, 1'b0);
      chk($sformatf("R5 alarm after block of %0d ones", k), alarm, int'(k < 13));
      chk($sformatf("R3 clr_evt block of %0d ones", k), clr_evt, int'(k >= 13));
      if (k == 13) begin
        step(1'b0, 1'b0);
        chk("R3 clr_evt drops", clr_evt, 0);
      end
    end

    // R5 failed block is followed by a fresh block
    enter_alarm(1'b0);
    win(burst(12), -1, 1'b0, 1'b0);
    chk("R5 12 ones keeps alarm", alarm, 1);
    win(burst(13), -1, 1'b0, 1'b0);
    chk("R5 next block clears", alarm, 0);

    // R6 zero-run sweep, strict standard
    for (int len = 10; len <= 20; len++) begin
      enter_alarm(1'b1);
      win(runpat(len), -1, 1'b1, 1'b0);
      chk($sformatf("R6 strict run %0d", len), alarm, int'(len > 15));
    end
    enter_alarm(1'b0);
    win(runpat(20), -1, 1'b0, 1'b0);
    chk("R6 density ignores run", alarm, 0);

    // R6 strict still needs density
    enter_alarm(1'b1);
    win(spaced(12), -1, 1'b1, 1'b0);
    chk("R6 strict 12 ones", alarm, 1);
    enter_alarm(1'b1);
    win(spaced(13), -1, 1'b1, 1'b0);
    chk("R6 strict 13 ones", alarm, 0);

    // R7 mid-block change is deferred to the next block
    enter_alarm(1'b0);
    win(runpat(20), 5, 1'b1, 1'b0);
    chk("R7 density held mid block", alarm, 0);
    enter_alarm(1'b1);
    win(runpat(20), 5, 1'b0, 1'b0);
    chk("R7 strict held mid block", alarm, 1);
    win(runpat(20), -1, 1'b0, 1'b0);
    chk("R7 new standard next block", alarm, 0);

    // R4 untick pulses do not count toward density
    enter_alarm(1'b0);
    win(burst(12), -1, 1'b0, 1'b1);
    chk("R4 gaps add no ones", alarm, 1);
    chk("R4 gaps no clr_evt", clr_evt, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule